// File: doc/BRIEF.md
# Comparator Edge Interrupt Debouncer

This block sits between the digital output of an analog comparator and the interrupt logic. It turns a noisy, slowly moving comparator bit into a clean edge-triggered interrupt flag. The raw bit passes through a two-flop synchronizer. Transitions are then qualified in one of four ways: accepted immediately at a sample strobe; confirmed over consecutive sample strobes; confirmed over consecutive overflow pulses of an external free-running timer; or rechecked after two such overflows. A qualified edge of the selected polarity sets a sticky flag. Software clears the flag, and the interrupt request is the flag gated by an enable bit.

The block has no data stream, only level and pulse control pins, so it has no valid/ready handshake. `samp_en` and `tmr_ovf` are single-cycle strobes from the surrounding logic. Software changes the input routing while `connect` is low, clears the flag, and then raises `irq_en` again. The block guarantees that this sequence raises no request.

Top module: `cmp_edge_debounce`

## Requirements
- R1: Reset clears `flag` and `irq`. Once the synchronizer has filled (three clock cycles after reset release), the reference level equals the synchronized input, so a level already present at reset produces no edge.
- R2: Mode `dbc_mode`=00 (immediate) accepts an edge at the first `samp_en` strobe that sees the changed synchronized level. `flag` is high within four clock cycles of the raw change when `samp_en` is held high.
- R3: `edge_sel` chooses the qualifying polarity: 00 rising only, 01 falling only, 10 or 11 either edge. An edge of the other polarity leaves `flag` unchanged.
- R4: Mode 01 takes samples on `samp_en`. A changed level must hold for 4 consecutive strobes before it counts as an edge. A strobe that shows the old level restarts the count.
- R5: Mode 10 takes samples on `tmr_ovf` instead and needs the same 4 consecutive samples. `samp_en` has no effect in this mode.
- R6: Mode 11 starts a wait when an edge of the selected polarity is seen at a `samp_en` strobe. The synchronized level is resampled on the second `tmr_ovf` pulse after the start. If it equals the level the edge implied, `flag` is set.
- R7: In mode 11, if the resampled level differs from the implied level, the event is discarded and `flag` does not change.
- R8: In mode 11, further transitions during a pending wait neither restart nor extend it. Only the resample result decides.
- R9: `flag` stays high until a cycle with `flag_clr` high clears it. A set request in the same cycle takes priority over the clear.
- R10: `irq` is high exactly when `flag` is high and `irq_en` is high.
- R11: While `connect` is low, no edge is detected and any pending wait is cancelled. The reference level follows the input, so reconnecting to a changed level produces no edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator output bit |
| samp_en | input | 1 | Sample strobe (modes 00, 01, 11) |
| tmr_ovf | input | 1 | Overflow pulse of the free-running timer |
| edge_sel | input | 2 | Edge polarity select |
| dbc_mode | input | 2 | Qualification mode select |
| connect | input | 1 | Comparator connection enable |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Software clear of the flag |
| flag | output | 1 | Sticky edge interrupt flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench targets the off-by-one boundaries of the confirm counter. Three matching samples must leave the flag low and the fourth must set it. A design that counts one sample short or long fails on one side of this boundary. In the recheck mode, the bench shows that one overflow is not enough. It then toggles the input during a pending wait: a design that restarts the wait would still show a low flag after the second overflow. A design that resamples at the wrong moment would accept the rejected pulse. The bench also drops `connect` in the middle of a wait and reconnects to a changed level. A design that keeps a stale reference or a live wait would set a spurious flag.

// File: rtl/cmpd_pkg.sv
package cmpd_pkg;

  typedef enum logic [1:0] {
    DBC_NONE  = 2'b00,
    DBC_SAMP4 = 2'b01,
    DBC_OVF4  = 2'b10,
    DBC_RECHK = 2'b11
  } dbc_mode_e;

  // Polarity match for a qualified edge whose new level is new_lvl.
  function automatic logic edge_match(input logic [1:0] sel, input logic new_lvl);
    unique case (sel)
      2'b00:   return new_lvl;
      2'b01:   return !new_lvl;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/cmpd_sync.sv
module cmpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/cmpd_confirm.sv
module cmpd_confirm #(
  parameter int CONFIRM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic track,
  input  logic strobe,
  input  logic long_win,
  input  logic lvl,
  output logic ev,
  output logic ev_lvl
);
  localparam int CW = $clog2(CONFIRM + 1);

  logic          ref_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;
  logic [CW:0]   cnt_nxt;

  assign need    = long_win ? CW'(CONFIRM) : CW'(1);
  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      cnt_q  <= '0;
      ev     <= 1'b0;
      ev_lvl <= 1'b0;
    end else begin
      ev <= 1'b0;
      if (track) begin
        ref_q <= lvl;
        cnt_q <= '0;
      end else if (strobe) begin
        if (lvl != ref_q) begin
          if (cnt_nxt >= {1'b0, need}) begin
            ref_q  <= lvl;
            cnt_q  <= '0;
            ev     <= 1'b1;
            ev_lvl <= lvl;
          end else begin
            cnt_q <= cnt_nxt[CW-1:0];
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/cmpd_recheck.sv
module cmpd_recheck #(
  parameter int OVF_WAIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cancel,
  input  logic start,
  input  logic start_lvl,
  input  logic ovf,
  input  logic lvl,
  output logic pending,
  output logic accept
);
  localparam int OW = $clog2(OVF_WAIT + 1);

  logic [OW-1:0] ocnt_q;
  logic          exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      ocnt_q  <= '0;
      exp_q   <= 1'b0;
      accept  <= 1'b0;
    end else begin
      accept <= 1'b0;
      if (cancel) begin
        pending <= 1'b0;
        ocnt_q  <= '0;
      end else if (!pending) begin
        if (start) begin
          pending <= 1'b1;
          exp_q   <= start_lvl;
          ocnt_q  <= '0;
        end
      end else if (ovf) begin
        if (ocnt_q == OW'(OVF_WAIT - 1)) begin
          pending <= 1'b0;
          ocnt_q  <= '0;
          accept  <= (lvl == exp_q);
        end else begin
          ocnt_q <= ocnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmp_edge_debounce.sv
module cmp_edge_debounce
  import cmpd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 4,
  parameter int OVF_WAIT    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_raw,
  input  logic       samp_en,
  input  logic       tmr_ovf,
  input  logic [1:0] edge_sel,
  input  logic [1:0] dbc_mode,
  input  logic       connect,
  input  logic       irq_en,
  input  logic       flag_clr,
  output logic       flag,
  output logic       irq
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int WW   = $clog2(WARM + 1);

  dbc_mode_e mode;
  logic          lvl_s;
  logic [WW-1:0] warm_q;
  logic          armed, track, strobe, long_win;
  logic          cf_ev, cf_lvl, match;
  logic          rchk_pending, rchk_accept, rchk_start, set_req;
  logic          flag_q;

  assign mode = dbc_mode_e'(dbc_mode);

  cmpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(lvl_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           warm_q <= '0;
    else if (!armed)      warm_q <= warm_q + 1'b1;
  end

  assign armed    = (warm_q == WW'(WARM));
  assign track    = !connect || !armed;
  assign strobe   = (mode == DBC_OVF4) ? tmr_ovf : samp_en;
  assign long_win = (mode == DBC_SAMP4) || (mode == DBC_OVF4);

  cmpd_confirm #(.CONFIRM(CONFIRM)) u_confirm (
    .clk(clk), .rst_n(rst_n), .track(track), .strobe(strobe),
    .long_win(long_win), .lvl(lvl_s), .ev(cf_ev), .ev_lvl(cf_lvl)
  );

  assign match      = edge_match(edge_sel, cf_lvl);
  assign rchk_start = (mode == DBC_RECHK) && cf_ev && match;

  cmpd_recheck #(.OVF_WAIT(OVF_WAIT)) u_recheck (
    .clk(clk), .rst_n(rst_n), .cancel(track || (mode != DBC_RECHK)),
    .start(rchk_start), .start_lvl(cf_lvl), .ovf(tmr_ovf), .lvl(lvl_s),
    .pending(rchk_pending), .accept(rchk_accept)
  );

  assign set_req = ((mode != DBC_RECHK) && cf_ev && match) || rchk_accept;

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (set_req)  flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q && irq_en;
endmodule

// File: rtl/cmpd_checker.sv
module cmpd_checker (
  input logic clk,
  input logic rst_n,
  input logic connect,
  input logic irq_en,
  input logic flag_clr,
  input logic flag,
  input logic irq,
  input logic pending,
  input logic accept
);
  // R11
  disc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(connect, 2));

  // R9
  clr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_clr));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R6
  accept_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> flag);

  // R11
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !connect |=> !pending);
endmodule

bind cmp_edge_debounce cmpd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .connect(connect), .irq_en(irq_en),
  .flag_clr(flag_clr), .flag(flag), .irq(irq),
  .pending(rchk_pending), .accept(rchk_accept)
);

// File: tb/tb_cmp_edge_debounce.sv
`timescale 1ns/100ps
module tb_cmp_edge_debounce;
  logic       clk = 1'b0;
  logic       rst_n, cmp_raw, samp_en, tmr_ovf, connect, irq_en, flag_clr;
  logic [1:0] edge_sel, dbc_mode;
  logic       flag, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct { logic f; logic i; string req; } exp_t;
  exp_t q[$];
  event chk_ev;

  always #2.5 clk = ~clk;

  cmp_edge_debounce dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .samp_en(samp_en),
    .tmr_ovf(tmr_ovf), .edge_sel(edge_sel), .dbc_mode(dbc_mode),
    .connect(connect), .irq_en(irq_en), .flag_clr(flag_clr),
    .flag(flag), .irq(irq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic samp_pulse(input int n);
    for (int k = 0; k < n; k++) begin
      samp_en = 1'b1; @(negedge clk);
      samp_en = 1'b0; @(negedge clk);
    end
  endtask

  task automatic ovf_pulse(input int n);
    for (int k = 0; k < n; k++) begin
      tmr_ovf = 1'b1; @(negedge clk);
      tmr_ovf = 1'b0; @(negedge clk);
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; @(negedge clk);
    flag_clr = 1'b0; cyc(2);
  endtask

  // Driver side of the scoreboard: push expectation, wake the monitor.
  task automatic expect_out(input logic f, input logic i, input string req);
    exp_t e;
    e.f = f; e.i = i; e.req = req;
    q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  // Monitor side: pop and compare against the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (flag !== e.f || irq !== e.i) begin
          errors++;
          $display("FAIL %s: flag=%0b irq=%0b expected flag=%0b irq=%0b",
                   e.req, flag, irq, e.f, e.i);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmp_raw = 1; samp_en = 1; tmr_ovf = 0; connect = 1;
    irq_en = 1; flag_clr = 0; edge_sel = 2'b00; dbc_mode = 2'b00;
    cyc(3);
    rst_n = 1;
    expect_out(0, 0, "R1");
    cyc(8);
    expect_out(0, 0, "R1");            // high level present at reset is no edge

    // R3: falling edge under rising select is ignored
    cmp_raw = 0; cyc(6); expect_out(0, 0, "R3");
    // R2: immediate mode rising edge
    cmp_raw = 1; cyc(4); expect_out(1, 1, "R2");
    // R9: sticky until cleared
    cyc(5); expect_out(1, 1, "R9");
    clear_flag(); expect_out(0, 0, "R9");

    // R3: falling select, then either select
    edge_sel = 2'b01; cmp_raw = 0; cyc(6); expect_out(1, 1, "R3");
    clear_flag();
    edge_sel = 2'b10; cmp_raw = 1; cyc(6); expect_out(1, 1, "R3");
    clear_flag();

    // R10: request gated by enable, no spurious request on re-enable
    irq_en = 0; cmp_raw = 0; cyc(6); expect_out(1, 0, "R10");
    clear_flag(); irq_en = 1; cyc(2); expect_out(0, 0, "R10");

    // R11: disconnected input detects nothing, reconnect gives no edge
    connect = 0; cmp_raw = 1; cyc(6); expect_out(0, 0, "R11");
    connect = 1; cyc(6); expect_out(0, 0, "R11");

    // R4: four consecutive samp_en strobes, count restart on old level
    dbc_mode = 2'b01; samp_en = 0; cyc(2);
    cmp_raw = 0; cyc(3); samp_pulse(2);
    cmp_raw = 1; cyc(3); samp_pulse(1);
    cmp_raw = 0; cyc(3); samp_pulse(3); cyc(3);
    expect_out(0, 0, "R4");
    samp_pulse(1); cyc(3); expect_out(1, 1, "R4");
    clear_flag();

    // R5: four consecutive overflow samples, samp_en ignored
    dbc_mode = 2'b10; samp_en = 1;
    cmp_raw = 1; cyc(3); ovf_pulse(3); cyc(3);
    expect_out(0, 0, "R5");
    ovf_pulse(1); cyc(3); expect_out(1, 1, "R5");
    clear_flag();

    // R6: two-overflow recheck, one overflow is not enough
    dbc_mode = 2'b11; edge_sel = 2'b00;
    cmp_raw = 0; cyc(6);
    cmp_raw = 1; cyc(6);
    ovf_pulse(1); cyc(3); expect_out(0, 0, "R6");
    ovf_pulse(1); cyc(3); expect_out(1, 1, "R6");
    clear_flag();

    // R7: level back to old value at resample, event discarded
    edge_sel = 2'b10;
    cmp_raw = 0; cyc(6);
    cmp_raw = 1; cyc(6);
    ovf_pulse(2); cyc(3); expect_out(0, 0, "R7");

    // R8: toggles during a pending wait do not restart it
    cmp_raw = 0; cyc(6);
    ovf_pulse(1);
    cmp_raw = 1; cyc(6);
    cmp_raw = 0; cyc(6);
    ovf_pulse(1); cyc(3); expect_out(1, 1, "R8");
    clear_flag();

    // R11: disconnect cancels a pending wait
    cmp_raw = 1; cyc(6);
    connect = 0; cyc(2); connect = 1; cyc(2);
    ovf_pulse(2); cyc(3); expect_out(0, 0, "R11");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule